// File: doc/BRIEF.md
# Lockable One-Time-Programmable Security Register Controller

This block manages a bank of write-once security words that sit beside a memory array. The bank holds eighteen lockable segments: a 64-bit factory identity that cannot be changed, a 64-bit segment free for the user, and sixteen 128-bit user segments. Two 16-bit lock words sit with them. Every cell is modelled as a flop that comes out of reset at 1, or at the factory identity value, and can only be driven toward 0. A program ANDs the new word into the old one, so no bit ever returns to 1.

The controller takes decoded bus commands: enter identifier mode, program a protection word, and any other command, which drops back to normal array mode. Reads of the bank are answered only in identifier mode, 16 bits at a time. Every program is checked against the protection window and against the lock bit of its segment. A refused program raises a one-cycle error pulse that a status unit can latch into its bit 4.

The word map is fixed, counted from word 0x80 of the low ten address bits: lock word 0 at 0x80, factory identity at 0x81–0x84 (least significant word first), user 64-bit segment at 0x85–0x88, lock word 1 at 0x89, and 128-bit segment k at 0x8A+8k to 0x91+8k. The last word is 0x109.

Top module: `otp_protreg`

## Requirements
- R1: After reset, progOk, progErr and rdHit are 0 and the controller is in normal array mode. Lock word 0 reads 0xFFFE, lock word 1 and every user word read 0xFFFF, and the factory words hold FACTORY_ID, with word 0x81 being bits 15:0.
- R2: A command with cmdCode 1 enters identifier mode. In that mode a read (rdEn) gives rdHit=1 one cycle later, with rdData equal to the addressed word. In normal mode a read gives rdHit=0 and rdData=0. Bit 0 of lock word 0 is a don't-care on reads.
- R3: cmdCode 0 and cmdCode 3 return the controller to normal mode. A protection program (cmdCode 2) leaves the mode unchanged.
- R4: An accepted program (cmdCode 2) stores old AND wrData at the addressed word and pulses progOk for one cycle, in the cycle after the command. The new value is visible to the next read.
- R5: Address bits 10 and above are ignored by both programs and reads. Only addr[9:0] selects a word.
- R6: A program with addr[9:0] below 0x80 or above 0x109 leaves every word unchanged and pulses progErr in the cycle after the command. progOk and progErr are never high together.
- R7: While bit 1 of lock word 0 is 0, programs to 0x85–0x88 are refused with progErr. While bit k of lock word 1 is 0, programs to 128-bit segment k are refused the same way. Refused words stay unchanged.
- R8: The factory words 0x81–0x84 are locked from reset, because bit 0 of lock word 0 is 0. Programs to them give progErr and change nothing.
- R9: The lock words themselves are always programmable. Their bits, and all other cells, never go from 0 back to 1.
- R10: A read asserted in the same cycle as any command is dropped, giving rdHit=0 in the next cycle.
- R11: In identifier mode, a read whose addr[9:0] lies outside 0x80–0x109 gives rdHit=1 and rdData=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A command is present this cycle |
| cmdCode | input | 2 | 0 array mode, 1 identifier mode, 2 protection program, 3 other |
| addr | input | ADDR_W | Word address; only bits 9:0 are decoded |
| wrData | input | 16 | Data ANDed into the word by a program |
| rdEn | input | 1 | Read request |
| rdData | output | 16 | Read data, valid while rdHit is 1, otherwise 0 |
| rdHit | output | 1 | The previous cycle's read was served in identifier mode |
| progOk | output | 1 | One-cycle pulse: program accepted |
| progErr | output | 1 | One-cycle pulse: program refused (range or lock) |

## Verification
Every result lands exactly one clock edge after its stimulus. progOk and progErr refer to the command of the previous cycle, and rdHit and rdData refer to the read of the previous cycle. The cell update and the mode change take effect at the same edge, so a read issued in the next cycle already sees them. The bench drives each operation just after a falling edge and samples one time unit after the following rising edge. It predicts all four outputs from a word model and a mode flag that it updates only after the comparison, so each check covers exactly one edge.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int DataW  = 16;
  localparam int RangeW = 10;  // decoded low address bits

  typedef enum logic [1:0] {
    CMD_ARRAY = 2'd0,
    CMD_IDENT = 2'd1,
    CMD_PROG  = 2'd2,
    CMD_OTHER = 2'd3
  } cmd_e;

  // strobes from control to storage
  typedef struct packed {
    logic              progWe;
    logic [RangeW-1:0] progIdx;
    logic [DataW-1:0]  progData;
    logic              rdEn;
    logic              rdInRange;
    logic [RangeW-1:0] rdIdx;
  } strobe_t;
endpackage

// File: rtl/otp_ctrl.sv
module otp_ctrl
  import otp_pkg::*;
#(
  parameter int NUM_BIG     = 16,
  parameter int BIG_WORDS   = 8,
  parameter int SMALL_WORDS = 4,
  parameter int MAP_BASE    = 'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdCode,
  input  logic [RangeW-1:0] lowAddr,
  input  logic [DataW-1:0]  wrData,
  input  logic              rdEn,
  input  logic [1:0]        lockLo,
  input  logic [NUM_BIG-1:0] lockBig,
  output strobe_t           strobe,
  output logic              progOk,
  output logic              progErr
);
  localparam int TotalWords = 2 + 2 * SMALL_WORDS + NUM_BIG * BIG_WORDS;
  localparam int FactOff    = 1;
  localparam int UserOff    = FactOff + SMALL_WORDS;
  localparam int Lock1Off   = UserOff + SMALL_WORDS;
  localparam int BigOff     = Lock1Off + 1;
  localparam int SegW       = (NUM_BIG > 1) ? $clog2(NUM_BIG) : 1;

  localparam logic [RangeW-1:0] BaseL  = RangeW'(MAP_BASE);
  localparam logic [RangeW-1:0] TotalL = RangeW'(TotalWords);
  localparam logic [RangeW-1:0] FactL  = RangeW'(FactOff);
  localparam logic [RangeW-1:0] UserL  = RangeW'(UserOff);
  localparam logic [RangeW-1:0] Lock1L = RangeW'(Lock1Off);
  localparam logic [RangeW-1:0] BigL   = RangeW'(BigOff);
  localparam logic [RangeW-1:0] BigWL  = RangeW'(BIG_WORDS);

  logic              idMode;
  logic [RangeW-1:0] off;
  logic [RangeW-1:0] segRel;
  logic              inRange;
  logic              segLocked;
  logic              isProg;
  logic              progAllowed;
  logic              unusedSegHi;

  assign off     = lowAddr - BaseL;
  assign inRange = (lowAddr >= BaseL) && (off < TotalL);
  assign segRel  = (off - BigL) / BigWL;
  assign unusedSegHi = ^segRel;

  always_comb begin
    segLocked = 1'b0;
    if (off >= FactL && off < UserL)       segLocked = ~lockLo[0];
    else if (off >= UserL && off < Lock1L) segLocked = ~lockLo[1];
    else if (off >= BigL)                  segLocked = ~lockBig[segRel[SegW-1:0]];
  end

  assign isProg      = cmdValid && (cmdCode == CMD_PROG);
  assign progAllowed = isProg && inRange && !segLocked;

  always_comb begin
    strobe           = '0;
    strobe.progWe    = progAllowed;
    strobe.progIdx   = off;
    strobe.progData  = wrData;
    strobe.rdEn      = rdEn && !cmdValid && idMode;
    strobe.rdInRange = inRange;
    strobe.rdIdx     = off;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idMode  <= 1'b0;
      progOk  <= 1'b0;
      progErr <= 1'b0;
    end else begin
      progOk  <= progAllowed;
      progErr <= isProg && !progAllowed;
      if (cmdValid) begin
        case (cmd_e'(cmdCode))
          CMD_IDENT: idMode <= 1'b1;
          CMD_PROG:  idMode <= idMode;
          default:   idMode <= 1'b0;
        endcase
      end
    end
  end

  // R6
  prog_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(progOk && progErr));

  // R6
  range_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == CMD_PROG && (lowAddr < BaseL || lowAddr >= BaseL + TotalL))
    |=> (progErr && !progOk));

  // R3
  mode_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (cmdCode == CMD_ARRAY || cmdCode == CMD_OTHER)) |=> !idMode);

  // R3
  mode_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == CMD_PROG) |=> $stable(idMode));
endmodule

// File: rtl/otp_store.sv
module otp_store
  import otp_pkg::*;
#(
  parameter int NUM_BIG     = 16,
  parameter int BIG_WORDS   = 8,
  parameter int SMALL_WORDS = 4,
  parameter logic [DataW*SMALL_WORDS-1:0] FACTORY_ID = 64'h5A3C_9E17_D204_6BF1
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  output logic [1:0]         lockLo,
  output logic [NUM_BIG-1:0] lockBig,
  output logic [DataW-1:0]   rdData,
  output logic               rdHit
);
  localparam int TotalWords = 2 + 2 * SMALL_WORDS + NUM_BIG * BIG_WORDS;
  localparam int IdxW       = $clog2(TotalWords);
  localparam int FactOff    = 1;
  localparam int UserOff    = FactOff + SMALL_WORDS;
  localparam int Lock1Off   = UserOff + SMALL_WORDS;

  logic [DataW-1:0] cells [TotalWords];
  logic [IdxW-1:0]  wIdx;
  logic [IdxW-1:0]  rIdx;
  logic             unusedIdxHi;

  assign wIdx = strobe.progIdx[IdxW-1:0];
  assign rIdx = strobe.rdIdx[IdxW-1:0];
  assign unusedIdxHi = ^{strobe.progIdx[RangeW-1:IdxW], strobe.rdIdx[RangeW-1:IdxW]};

  function automatic logic [DataW-1:0] resetWord(input int i);
    if (i == 0) return 16'hFFFE;  // factory segment locked from the start
    if (i >= FactOff && i < UserOff)
      return DataW'(FACTORY_ID >> (DataW * (i - FactOff)));
    return '1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < TotalWords; i++) cells[i] <= resetWord(i);
    end else if (strobe.progWe) begin
      cells[wIdx] <= cells[wIdx] & strobe.progData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdHit  <= 1'b0;
      rdData <= '0;
    end else begin
      rdHit  <= strobe.rdEn;
      rdData <= (strobe.rdEn && strobe.rdInRange) ? cells[rIdx] : '0;
    end
  end

  assign lockLo  = cells[0][1:0];
  assign lockBig = cells[Lock1Off][NUM_BIG-1:0];

  // checker state: previous write target and its old value
  logic             chkValid;
  logic [IdxW-1:0]  chkIdx;
  logic [DataW-1:0] chkOld;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkValid <= 1'b0;
      chkIdx   <= '0;
      chkOld   <= '0;
    end else begin
      chkValid <= strobe.progWe;
      chkIdx   <= wIdx;
      chkOld   <= cells[wIdx];
    end
  end

  // R9
  cell_monotone_chk: assert property (@(posedge clk) disable iff (!rstN)
    chkValid |-> ((cells[chkIdx] & ~chkOld) == '0));

  // R8
  factory_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    cells[0][0] == 1'b0);

  // R8
  factory_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.progWe && wIdx >= IdxW'(FactOff) && wIdx < IdxW'(UserOff)));
endmodule

// File: rtl/otp_protreg.sv
module otp_protreg
  import otp_pkg::*;
#(
  parameter int ADDR_W      = 23,
  parameter int NUM_BIG     = 16,
  parameter int BIG_WORDS   = 8,
  parameter int SMALL_WORDS = 4,
  parameter int MAP_BASE    = 'h80,
  parameter logic [DataW*SMALL_WORDS-1:0] FACTORY_ID = 64'h5A3C_9E17_D204_6BF1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdCode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DataW-1:0]  wrData,
  input  logic              rdEn,
  output logic [DataW-1:0]  rdData,
  output logic              rdHit,
  output logic              progOk,
  output logic              progErr
);
  strobe_t            strobe;
  logic [1:0]         lockLo;
  logic [NUM_BIG-1:0] lockBig;
  logic               unusedAddrHi;

  // bits at and above RangeW take no part in decoding (R5)
  assign unusedAddrHi = ^addr[ADDR_W-1:RangeW];

  otp_ctrl #(
    .NUM_BIG(NUM_BIG), .BIG_WORDS(BIG_WORDS),
    .SMALL_WORDS(SMALL_WORDS), .MAP_BASE(MAP_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .lowAddr(addr[RangeW-1:0]), .wrData(wrData), .rdEn(rdEn),
    .lockLo(lockLo), .lockBig(lockBig), .strobe(strobe),
    .progOk(progOk), .progErr(progErr)
  );

  otp_store #(
    .NUM_BIG(NUM_BIG), .BIG_WORDS(BIG_WORDS),
    .SMALL_WORDS(SMALL_WORDS), .FACTORY_ID(FACTORY_ID)
  ) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lockLo(lockLo),
    .lockBig(lockBig), .rdData(rdData), .rdHit(rdHit)
  );

  // R10
  read_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdHit |-> $past(rdEn && !cmdValid));

  // R2
  read_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdHit |-> (rdData == '0));
endmodule

// File: tb/otp_protreg_tb.sv
`timescale 1ns/100ps
module otp_protreg_tb;
  localparam int NWORDS = 138;
  localparam logic [63:0] FID = 64'h5A3C_9E17_D204_6BF1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdCode = 2'd0;
  logic [22:0] addr = '0;
  logic [15:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [15:0] rdData;
  logic        rdHit, progOk, progErr;

  int total = 0;
  int fails = 0;
  bit done = 0;

  logic [15:0] model [NWORDS];
  bit modeId = 0;

  always #2.5 clk = ~clk;

  otp_protreg u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .addr(addr), .wrData(wrData), .rdEn(rdEn), .rdData(rdData),
    .rdHit(rdHit), .progOk(progOk), .progErr(progErr)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int offOf(input logic [22:0] a);
    return int'(a[9:0]) - 128;
  endfunction

  function automatic bit inRangeOf(input logic [22:0] a);
    int o = offOf(a);
    return (o >= 0) && (o < NWORDS);
  endfunction

  function automatic bit lockedOf(input int o);
    if (o >= 1 && o <= 4) return model[0][0] == 1'b0;
    if (o >= 5 && o <= 8) return model[0][1] == 1'b0;
    if (o >= 10)          return model[9][(o - 10) / 8] == 1'b0;
    return 1'b0;
  endfunction

  task automatic doOp(input bit cv, input logic [1:0] cc, input logic [22:0] a,
                      input logic [15:0] d, input bit re, input string tag);
    bit isProg, inR, eOk, eErr, eHit;
    logic [15:0] eData, mask;
    int o;
    @(negedge clk);
    cmdValid = cv; cmdCode = cc; addr = a; wrData = d; rdEn = re;
    o      = offOf(a);
    inR    = inRangeOf(a);
    isProg = cv && (cc == 2'd2);
    eOk    = isProg && inR && !lockedOf(o);
    eErr   = isProg && !eOk;
    eHit   = re && !cv && modeId;
    eData  = (eHit && inR) ? model[o] : 16'h0;
    mask   = (eHit && inR && o == 0) ? 16'hFFFE : 16'hFFFF;  // lock0 bit0 don't-care
    @(posedge clk);
    #1;
    check(progOk == eOk, tag, "progOk", 16'(progOk), 16'(eOk));
    check(progErr == eErr, tag, "progErr", 16'(progErr), 16'(eErr));
    check(rdHit == eHit, tag, "rdHit", 16'(rdHit), 16'(eHit));
    check((rdData & mask) == (eData & mask), tag, "rdData", rdData & mask, eData & mask);
    if (eOk) model[o] = model[o] & d;
    if (cv) begin
      if (cc == 2'd1) modeId = 1;
      else if (cc != 2'd2) modeId = 0;
    end
    cmdValid = 0; rdEn = 0;
  endtask

  task automatic rd(input logic [22:0] a, input string tag);
    doOp(0, 2'd0, a, 16'h0, 1, tag);
  endtask
  task automatic prog(input logic [22:0] a, input logic [15:0] d, input string tag);
    doOp(1, 2'd2, a, d, 0, tag);
  endtask
  task automatic cmd(input logic [1:0] c, input string tag);
    doOp(1, c, 23'h0, 16'h0, 0, tag);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NWORDS; i++) model[i] = 16'hFFFF;
    model[0] = 16'hFFFE;
    for (int i = 0; i < 4; i++) model[1 + i] = FID[16*i +: 16];
    void'($urandom(32'd20240611));

    repeat (3) @(posedge clk);
    #1;
    // R1 outputs held at zero under reset
    check(!progOk && !progErr && !rdHit, "R1", "reset outs",
          16'({progOk, progErr, rdHit}), 16'h0);
    @(negedge clk); rstN = 1;

    // R2 normal mode does not answer
    rd(23'h081, "R2");
    cmd(2'd1, "R2");
    // R1 full reset image, R2 identifier reads
    for (int i = 0; i < NWORDS; i++) rd(23'(128 + i), "R1");
    // R5 high address bits ignored on read
    rd(23'h7FFC81, "R5");
    // R11 outside window
    rd(23'h07F, "R11");
    rd(23'h10A, "R11");
    // R4 program and read back
    prog(23'h085, 16'hF0F0, "R4");
    rd(23'h085, "R4");
    prog(23'h085, 16'h3CFF, "R4");
    rd(23'h085, "R4");
    // R5 high bits ignored on program
    prog(23'h155C86, 16'h1234, "R5");
    rd(23'h086, "R5");
    // R6 out of range programs
    prog(23'h07F, 16'h0000, "R6");
    prog(23'h10A, 16'h0000, "R6");
    prog(23'h40010A, 16'h0000, "R6");
    // R8 factory words refused
    prog(23'h081, 16'h0000, "R8");
    rd(23'h081, "R8");
    prog(23'h084, 16'h0000, "R8");
    rd(23'h084, "R8");
    // R7 lock user 64-bit segment
    prog(23'h080, 16'hFFFD, "R7");
    prog(23'h087, 16'h0000, "R7");
    rd(23'h087, "R7");
    // R7 lock 128-bit segment 3, segment 4 still open
    prog(23'h089, 16'hFFF7, "R7");
    prog(23'(138 + 24 + 2), 16'h00FF, "R7");
    rd(23'(138 + 24 + 2), "R7");
    prog(23'(138 + 32 + 2), 16'h00FF, "R7");
    rd(23'(138 + 32 + 2), "R7");
    // R9 lock bits stay cleared
    prog(23'h080, 16'hFFFF, "R9");
    rd(23'h080, "R9");
    prog(23'h089, 16'hFFFF, "R9");
    rd(23'h089, "R9");
    // R10 read with a command in the same cycle is dropped
    doOp(1, 2'd2, 23'h088, 16'hFFFE, 1, "R10");
    rd(23'h088, "R10");
    // R3 program keeps identifier mode, other and array commands leave it
    rd(23'h08A, "R3");
    cmd(2'd3, "R3");
    rd(23'h08A, "R3");
    cmd(2'd1, "R3");
    cmd(2'd0, "R3");
    rd(23'h08A, "R3");
    cmd(2'd1, "R3");

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      int kind = $urandom_range(0, 99);
      logic [22:0] a;
      logic [15:0] d;
      if ($urandom_range(0, 9) < 8)
        a = {13'($urandom), 10'(128 + $urandom_range(0, NWORDS - 1))};
      else
        a = 23'($urandom);
      d = ($urandom_range(0, 9) == 0) ? 16'($urandom) : ~(16'h1 << $urandom_range(0, 15));
      if (kind < 40)      prog(a, d, "R4");
      else if (kind < 85) doOp($urandom_range(0, 19) == 0, 2'd2, a, d, 1, "R2");
      else if (kind < 95) cmd(2'd1, "R3");
      else                cmd(($urandom_range(0, 1) == 0) ? 2'd0 : 2'd3, "R3");
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule